// File: doc/BRIEF.md
# Binary Tree Up-Down Route Computer

This block plans routes through a complete binary tree of switches that has `LEVELS` switch levels above its leaves. A request carries a source leaf and a destination leaf, each `LEVELS` bits wide. The block XORs the two addresses and finds the highest bit where they differ. That bit sets how many levels a packet must climb before it reaches the nearest shared ancestor. On the way back down, the packet is steered by the low bits of the destination, taken from the most significant of those bits first.

The block produces two forms of the same answer. A summary form is valid for one cycle and gives the climb height, the descent branch bits and a local-delivery flag. A step-by-step form walks the path one hop per cycle: every up hop first, then every down hop with its child select, then a one-cycle completion pulse. A checker can follow the step form and confirm each hop.

Top module: `tree_updown_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_valid`, `hop_valid` and `path_done` are 0.
- R2: A request strobe that the block accepts raises `res_valid` for exactly one cycle, in the cycle after the accepting clock edge.
- R3: `climb_count` equals one plus the bit position of the highest 1 in `src_leaf ^ dst_leaf`, or 0 when that XOR is zero.
- R4: `down_path` holds the low `climb_count` bits of `dst_leaf`, and all of its higher bits are 0.
- R5: `local_hit` is 1 exactly when source equals destination. In that case `climb_count` and `down_path` are 0.
- R6: The hop stream starts in the same cycle as `res_valid`. It begins with `climb_count` hops on consecutive cycles that have `hop_valid`=1, `hop_is_down`=0 and `hop_child`=0.
- R7: Next come `climb_count` hops with `hop_is_down`=1. Down hop j (counting from 0) carries `hop_child` = bit (`climb_count`-1-j) of `dst_leaf`, so the most significant branch bit goes first. An up hop never follows a down hop within one path.
- R8: `path_done` pulses for one cycle, with `hop_valid` at 0, in the cycle after the last down hop. For a local route it pulses in the same cycle as `res_valid`.
- R9: A strobe that arrives while a path is still being emitted (from acceptance until after `path_done`) is ignored. No new `res_valid` appears and the hop stream in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| src_leaf | input | LEVELS | Source leaf address |
| dst_leaf | input | LEVELS | Destination leaf address |
| res_valid | output | 1 | Summary result valid, one cycle |
| climb_count | output | $clog2(LEVELS+1) | Levels to climb to the shared ancestor |
| down_path | output | LEVELS | Descent branch bits (low climb_count bits of destination) |
| local_hit | output | 1 | Source equals destination |
| hop_valid | output | 1 | A hop is presented this cycle |
| hop_is_down | output | 1 | 0 = up hop, 1 = down hop |
| hop_child | output | 1 | Child select for a down hop (0 on up hops) |
| path_done | output | 1 | Path complete, one cycle |

## Verification
Call t=0 the cycle after the edge that accepted a request. The summary fields, `res_valid` and the first hop are all due at t=0. With c levels to climb, hop k is due at t=k, and `path_done` is due at t=2c, after which the block is idle. The bench sweeps every source/destination pair for a three-level and a four-level tree. It drives inputs and samples outputs on the falling clock edge and steps its expected-cycle index once per falling edge, so each value is compared in the exact cycle it is due. During every non-local path the bench also fires a spare strobe at t=0 and checks that no later cycle shows any effect from it.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CLIMB,
    SEQ_DESCEND,
    SEQ_FINISH
  } seq_state_e;

  // Position of the highest set bit plus one, scanning the low n bits; 0 if none.
  function automatic int unsigned top_set_bit_plus1(input logic [31:0] v,
                                                    input int unsigned n);
    int unsigned r;
    r = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < n && v[k]) r = k + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tree_turn_finder.sv
module tree_turn_finder
  import tree_route_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int CW     = $clog2(LEVELS + 1)
) (
  input  logic [LEVELS-1:0] src,
  input  logic [LEVELS-1:0] dst,
  output logic [CW-1:0]     climb,
  output logic [LEVELS-1:0] down_bits,
  output logic              is_local
);

  logic [LEVELS-1:0] diff;
  logic [LEVELS-1:0] keep_mask;

  assign diff     = src ^ dst;
  assign climb    = CW'(top_set_bit_plus1(32'(diff), LEVELS));
  assign is_local = (diff == '0);

  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign keep_mask[g] = (CW'(g) < climb);
  end

  assign down_bits = dst & keep_mask;

endmodule

// File: rtl/tree_hop_sequencer.sv
module tree_hop_sequencer
  import tree_route_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int CW     = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     climb_in,
  input  logic [LEVELS-1:0] dst_in,
  output logic              hop_valid,
  output logic              hop_is_down,
  output logic              hop_child,
  output logic              path_done,
  output logic              idle
);

  seq_state_e        state;
  logic [CW-1:0]     step;
  logic [CW-1:0]     climb_q;
  logic [LEVELS-1:0] dst_q;
  logic              last_step;
  logic [LEVELS-1:0] dst_shifted;

  assign last_step = (step == climb_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      step    <= '0;
      climb_q <= '0;
      dst_q   <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            climb_q <= climb_in;
            dst_q   <= dst_in;
            step    <= '0;
            state   <= (climb_in == '0) ? SEQ_FINISH : SEQ_CLIMB;
          end
        end
        SEQ_CLIMB: begin
          if (last_step) begin
            step  <= '0;
            state <= SEQ_DESCEND;
          end else begin
            step <= step + CW'(1);
          end
        end
        SEQ_DESCEND: begin
          if (last_step) begin
            step  <= '0;
            state <= SEQ_FINISH;
          end else begin
            step <= step + CW'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign dst_shifted = dst_q >> (climb_q - CW'(1) - step);
  assign hop_valid   = (state == SEQ_CLIMB) || (state == SEQ_DESCEND);
  assign hop_is_down = (state == SEQ_DESCEND);
  assign hop_child   = hop_is_down & dst_shifted[0];
  assign path_done   = (state == SEQ_FINISH);
  assign idle        = (state == SEQ_IDLE);

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> (step < climb_q)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    path_done |=> !path_done); // R8
  AST_DOWN_FOLLOWS_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && hop_is_down) |-> $past(hop_valid)); // R7
  AST_NO_UP_AFTER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && !hop_is_down) |-> !$past(hop_valid && hop_is_down)); // R7
  AST_DONE_NO_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    path_done |-> !hop_valid); // R8

endmodule

// File: rtl/tree_updown_router.sv
module tree_updown_router
  import tree_route_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int CW    = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEVELS-1:0] src_leaf,
  input  logic [LEVELS-1:0] dst_leaf,
  output logic              res_valid,
  output logic [CW-1:0]     climb_count,
  output logic [LEVELS-1:0] down_path,
  output logic              local_hit,
  output logic              hop_valid,
  output logic              hop_is_down,
  output logic              hop_child,
  output logic              path_done
);

  logic [CW-1:0]     tf_climb;
  logic [LEVELS-1:0] tf_down;
  logic              tf_local;
  logic              seq_idle;
  logic              accept;

  assign accept = req_valid && seq_idle;

  tree_turn_finder #(.LEVELS(LEVELS), .CW(CW)) turn_i (
    .src       (src_leaf),
    .dst       (dst_leaf),
    .climb     (tf_climb),
    .down_bits (tf_down),
    .is_local  (tf_local)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      climb_count <= '0;
      down_path   <= '0;
      local_hit   <= 1'b0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        climb_count <= tf_climb;
        down_path   <= tf_down;
        local_hit   <= tf_local;
      end
    end
  end

  tree_hop_sequencer #(.LEVELS(LEVELS), .CW(CW)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .climb_in    (tf_climb),
    .dst_in      (dst_leaf),
    .hop_valid   (hop_valid),
    .hop_is_down (hop_is_down),
    .hop_child   (hop_child),
    .path_done   (path_done),
    .idle        (seq_idle)
  );

  AST_RES_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R2
  AST_CLIMB_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (climb_count <= CW'(LEVELS))); // R3
  AST_DOWN_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((down_path >> climb_count) == '0)); // R4
  AST_LOCAL_NO_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && local_hit) |-> (climb_count == '0 && down_path == '0)); // R5
  AST_FIRST_HOP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !local_hit) |-> (hop_valid && !hop_is_down)); // R6
  AST_LOCAL_DONE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && local_hit) |-> path_done); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seq_idle) |=> !res_valid); // R9

endmodule

// File: tb/tree_updown_router_sweep.sv
module tree_updown_router_sweep #(
  parameter int LVL = 3
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_cmp,
  output int   n_bad,
  output logic finished
);

  localparam int CWB = $clog2(LVL + 1);

  logic           req_valid;
  logic [LVL-1:0] src_leaf;
  logic [LVL-1:0] dst_leaf;
  logic           res_valid;
  logic [CWB-1:0] climb_count;
  logic [LVL-1:0] down_path;
  logic           local_hit;
  logic           hop_valid;
  logic           hop_is_down;
  logic           hop_child;
  logic           path_done;

  tree_updown_router #(.LEVELS(LVL)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .src_leaf    (src_leaf),
    .dst_leaf    (dst_leaf),
    .res_valid   (res_valid),
    .climb_count (climb_count),
    .down_path   (down_path),
    .local_hit   (local_hit),
    .hop_valid   (hop_valid),
    .hop_is_down (hop_is_down),
    .hop_child   (hop_child),
    .path_done   (path_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (LEVELS=%0d, t=%0t): actual %0d expected %0d", tag, LVL, $time, act, exp);
    end
  endtask

  task automatic run_pair(input int a, input int b);
    int c;
    int exp_down;
    c        = $clog2((a ^ b) + 1);
    exp_down = b % (1 << c);
    src_leaf  = LVL'(a);
    dst_leaf  = LVL'(b);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 res_valid", int'(res_valid), 1);
    chk("R3 climb_count", int'(climb_count), c);
    chk("R4 down_path", int'(down_path), exp_down);
    chk("R5 local_hit", int'(local_hit), (a == b) ? 1 : 0);
    for (int t = 0; t <= 2 * c; t++) begin
      if (t == 1 && c > 0) chk("R9 res_valid after busy strobe", int'(res_valid), 0);
      else if (t > 0) chk("R2 res_valid single cycle", int'(res_valid), 0);
      if (t < c) begin
        chk("R6 up hop", {29'd0, hop_valid, hop_is_down, hop_child}, 3'b100);
      end else if (t < 2 * c) begin
        chk("R7 down hop", {30'd0, hop_valid, hop_is_down}, 2'b11);
        chk("R7 child select", int'(hop_child), (b >> (c - 1 - (t - c))) & 1);
      end else begin
        chk("R8 done pulse", {30'd0, path_done, hop_valid}, 2'b10);
      end
      if (t == 0 && c > 0) begin
        src_leaf  = ~LVL'(a);
        dst_leaf  = LVL'(a);
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R8 done single cycle", int'(path_done), 0);
    chk("R9 idle after path", {30'd0, res_valid, hop_valid}, 0);
  endtask

  initial begin
    n_cmp     = 0;
    n_bad     = 0;
    finished  = 1'b0;
    req_valid = 1'b0;
    src_leaf  = '0;
    dst_leaf  = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {29'd0, res_valid, hop_valid, path_done}, 0);
    wait (rst_n);
    @(negedge clk);
    chk("R1 after reset", {29'd0, res_valid, hop_valid, path_done}, 0);
    for (int a = 0; a < (1 << LVL); a++) begin
      for (int b = 0; b < (1 << LVL); b++) begin
        run_pair(a, b);
      end
    end
    finished = 1'b1;
  end

endmodule

// File: tb/tree_updown_router_tb_top.sv
module tree_updown_router_tb_top;

  logic clk;
  logic rst_n;
  int   c3, b3, c4, b4;
  logic f3, f4;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
  end

  tree_updown_router_sweep #(.LVL(3)) sweep3_i (
    .clk(clk), .rst_n(rst_n), .n_cmp(c3), .n_bad(b3), .finished(f3)
  );
  tree_updown_router_sweep #(.LVL(4)) sweep4_i (
    .clk(clk), .rst_n(rst_n), .n_cmp(c4), .n_bad(b4), .finished(f4)
  );

  initial begin
    int cyc;
    int wd_cmp;
    int wd_bad;
    cyc    = 0;
    wd_cmp = 0;
    wd_bad = 0;
    while (!(f3 === 1'b1 && f4 === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(f3 === 1'b1 && f4 === 1'b1)) begin
      wd_cmp = 1;
      wd_bad = 1;
      $display("FAIL R1-sweep watchdog expired: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             c3 + c4 + wd_cmp, b3 + b4 + wd_bad);
    $finish;
  end

endmodule